// File: doc/BRIEF.md
# Exception State Register Unit

This block keeps the machine-level exception state of a simple processor in four 32-bit registers: the faulting memory address, the status word, the cause word and the exception return address. When an exception is taken, it updates all of them in a single cycle. It records the reason code and the address of the offending instruction. It captures a faulting data address when one is supplied. It pushes the mode and enable stack in the status word, so that the handler runs in kernel mode with interrupts disabled. A return-from-exception strobe pops that stack again.

Five hardware interrupt request lines are sampled on every clock. Each request is held as a pending bit in the cause word until an external-interrupt exception acknowledges it. The block combines the pending bits with the per-level mask bits in the status word and the current enable bit. The result is a single interrupt-take output for the sequencer. Software reads the registers combinationally through a register-number port and writes them through a write port. Fields that the block does not define read as zero.

Top module: `exc_state_regs`

## Requirements
- R1: After a synchronous reset, all four registers read zero and `ie_cur`, `user_mode` and `irq_take` are 0.
- R2: `rd_data` combinationally returns the faulting-address register for register number 8, status for 12, cause for 13 and the exception return address for 14. Any other number reads zero. Undefined bits read zero: status bits 31..16 and 7..6, and cause bits 31..16, 10..6 and 1..0.
- R3: When `exc_valid` is high at a clock edge, status bits 5..0 become the old bits 3..0 shifted up by two, with bits 1..0 cleared. From the next cycle `ie_cur` and `user_mode` are 0. Status bits 15..8 are unchanged.
- R4: When `rfe` is high and `exc_valid` is low, status bits 3..0 take the old bits 5..2 and bits 5..4 keep their value. When `rfe` and `exc_valid` are high together, only the exception takes effect.
- R5: On an exception, cause bits 5..2 take `exc_code`. The exception return register takes `exc_pc`, which is the offending instruction's own address and not its successor's. Code 0 means external interrupt.
- R6: On an exception, the faulting-address register is loaded from `exc_fault_addr` only when `exc_fault_valid` is high. Otherwise it keeps its value.
- R7: A high `hw_irq[i]` sets cause bit 11+i at the next edge, whatever the enable and mask bits are. The bit stays set while the line is low. On an exception with code 0, every pending bit reloads from the current `hw_irq` value.
- R8: A software write (`sw_we`) to number 12 loads status bits 15..8 and 5..0. A write to 13 loads only cause bits 5..2, and writes to the pending field are ignored. Writes to 14 and 8 load the whole word, and writes to other numbers change nothing. An exception in the same cycle blocks every software write. An `rfe` in the same cycle blocks a status write.
- R9: `irq_take` is high exactly when status bit 0 is 1 and some cause bit 11+i is set together with status mask bit 11+i. Status bits 10..8, the software levels, are stored but do not affect `irq_take`.
- R10: `ie_cur` equals status bit 0 and `user_mode` equals status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software register write strobe |
| sw_addr | input | 5 | Register number for software write |
| sw_wdata | input | 32 | Software write data |
| rd_addr | input | 5 | Register number for read |
| rd_data | output | 32 | Read data, combinational |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 4 | Exception reason code |
| exc_pc | input | 32 | Address of offending instruction |
| exc_fault_valid | input | 1 | Faulting address supplied with the exception |
| exc_fault_addr | input | 32 | Faulting memory address |
| hw_irq | input | 5 | Hardware interrupt request lines |
| rfe | input | 1 | Return-from-exception strobe |
| ie_cur | output | 1 | Current interrupt enable |
| user_mode | output | 1 | Current mode, 1 = user |
| irq_take | output | 1 | An enabled, unmasked interrupt is pending |

## Verification
Several relations are checked on every clock: the stack push on an exception, the pop on a return, and the kernel-with-interrupts-off state after an exception. So are the capture of the return address, the sticky set of pending bits, and the rule that nothing is taken while the current enable is low. Other behaviour only shows in the bench's scenarios against its word-level reference model. This covers the precedence among an exception, a return and a software write that arrive together. It also covers the ignored writes to the pending field and to unknown register numbers, the zero reads of undefined bits, and the fact that software mask levels do not affect `irq_take`.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int DATA_W    = 32;
    localparam int RNUM_W    = 5;
    localparam int N_HW_IRQ  = 5;
    localparam int N_SW_IRQ  = 3;
    localparam int MASK_W    = N_HW_IRQ + N_SW_IRQ;
    localparam int MASK_LO   = 8;
    localparam int MASK_HI   = MASK_LO + MASK_W - 1;
    localparam int PEND_LO   = MASK_LO + N_SW_IRQ;
    localparam int PEND_HI   = PEND_LO + N_HW_IRQ - 1;
    localparam int STK_W     = 6;
    localparam int CODE_W    = 4;
    localparam int CODE_LO   = 2;
    localparam int CODE_HI   = CODE_LO + CODE_W - 1;

    localparam logic [RNUM_W-1:0] RN_FAULT  = 5'd8;
    localparam logic [RNUM_W-1:0] RN_STATUS = 5'd12;
    localparam logic [RNUM_W-1:0] RN_CAUSE  = 5'd13;
    localparam logic [RNUM_W-1:0] RN_EPC    = 5'd14;

    typedef enum logic [CODE_W-1:0] {
        EXC_INT   = 4'd0,
        EXC_ADRL  = 4'd4,
        EXC_ADRS  = 4'd5,
        EXC_IBUS  = 4'd6,
        EXC_DBUS  = 4'd7,
        EXC_SYS   = 4'd8,
        EXC_BRK   = 4'd9,
        EXC_RSVD  = 4'd10,
        EXC_OVF   = 4'd12
    } exc_code_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [STK_W-1:0]  stk;
    } status_t;

    typedef struct packed {
        logic [N_HW_IRQ-1:0] pend;
        logic [CODE_W-1:0]   code;
    } cause_t;

    typedef struct packed {
        logic fault;
        logic status;
        logic cause;
        logic epc;
    } reg_sel_t;

    function automatic logic [STK_W-1:0] stk_push(input logic [STK_W-1:0] s);
        return {s[STK_W-3:0], 2'b00};
    endfunction

    function automatic logic [STK_W-1:0] stk_pop(input logic [STK_W-1:0] s);
        return {s[STK_W-1:STK_W-2], s[STK_W-1:2]};
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input status_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MASK_HI:MASK_LO] = s.mask;
        w[STK_W-1:0]       = s.stk;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] cause_word(input cause_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PEND_HI:PEND_LO] = c.pend;
        w[CODE_HI:CODE_LO] = c.code;
        return w;
    endfunction

    function automatic reg_sel_t decode_rnum(input logic [RNUM_W-1:0] n);
        reg_sel_t r;
        r.fault  = (n == RN_FAULT);
        r.status = (n == RN_STATUS);
        r.cause  = (n == RN_CAUSE);
        r.epc    = (n == RN_EPC);
        return r;
    endfunction

endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_take,
    input  logic              rfe,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [STK_W-1:0]  wr_stk,
    output status_t           st_q
);

    status_t st_d;

    always_comb begin
        st_d = st_q;
        if (exc_take) begin
            st_d.stk = stk_push(st_q.stk);
        end else if (rfe) begin
            st_d.stk = stk_pop(st_q.stk);
        end else if (wr_en) begin
            st_d.mask = wr_mask;
            st_d.stk  = wr_stk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                exc_take,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic                wr_en,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic [N_HW_IRQ-1:0] hw_irq,
    output cause_t              cause_q
);

    logic                int_ack;
    logic [N_HW_IRQ-1:0] pend_d;
    logic [CODE_W-1:0]   code_d;

    assign int_ack = exc_take && (exc_code == EXC_INT);

    for (genvar i = 0; i < N_HW_IRQ; i++) begin : g_pend
        assign pend_d[i] = hw_irq[i] | (cause_q.pend[i] & ~int_ack);
    end

    always_comb begin
        code_d = cause_q.code;
        if (exc_take) begin
            code_d = exc_code;
        end else if (wr_en) begin
            code_d = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q.pend <= pend_d;
            cause_q.code <= code_d;
        end
    end

endmodule

// File: rtl/exc_addr_reg.sv
module exc_addr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap_en) begin
            q <= cap_data;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_we,
    input  logic [RNUM_W-1:0]   sw_addr,
    input  logic [DATA_W-1:0]   sw_wdata,
    input  logic [RNUM_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                exc_valid,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [DATA_W-1:0]   exc_pc,
    input  logic                exc_fault_valid,
    input  logic [DATA_W-1:0]   exc_fault_addr,
    input  logic [N_HW_IRQ-1:0] hw_irq,
    input  logic                rfe,
    output logic                ie_cur,
    output logic                user_mode,
    output logic                irq_take
);

    reg_sel_t            wsel;
    reg_sel_t            rsel;
    status_t             st_q;
    cause_t              cause_q;
    logic [DATA_W-1:0]   epc_q;
    logic [DATA_W-1:0]   fault_q;
    logic [STK_W-1:0]    stk_w;
    logic [N_HW_IRQ-1:0] pend_w;
    logic [N_HW_IRQ-1:0] hw_mask_w;

    assign wsel = sw_we ? decode_rnum(sw_addr) : '0;
    assign rsel = decode_rnum(rd_addr);

    exc_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_valid),
        .rfe      (rfe),
        .wr_en    (wsel.status),
        .wr_mask  (sw_wdata[MASK_HI:MASK_LO]),
        .wr_stk   (sw_wdata[STK_W-1:0]),
        .st_q     (st_q)
    );

    exc_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_valid),
        .exc_code (exc_code),
        .wr_en    (wsel.cause),
        .wr_code  (sw_wdata[CODE_HI:CODE_LO]),
        .hw_irq   (hw_irq),
        .cause_q  (cause_q)
    );

    exc_addr_reg #(.W(DATA_W)) u_epc (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (exc_valid),
        .cap_data (exc_pc),
        .wr_en    (wsel.epc && !exc_valid),
        .wr_data  (sw_wdata),
        .q        (epc_q)
    );

    exc_addr_reg #(.W(DATA_W)) u_fault (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (exc_valid && exc_fault_valid),
        .cap_data (exc_fault_addr),
        .wr_en    (wsel.fault && !exc_valid),
        .wr_data  (sw_wdata),
        .q        (fault_q)
    );

    always_comb begin
        rd_data = '0;
        unique case (1'b1)
            rsel.fault:  rd_data = fault_q;
            rsel.status: rd_data = status_word(st_q);
            rsel.cause:  rd_data = cause_word(cause_q);
            rsel.epc:    rd_data = epc_q;
            default:     rd_data = '0;
        endcase
    end

    assign stk_w     = st_q.stk;
    assign pend_w    = cause_q.pend;
    assign hw_mask_w = st_q.mask[MASK_W-1:N_SW_IRQ];

    assign ie_cur    = st_q.stk[0];
    assign user_mode = st_q.stk[1];
    assign irq_take  = ie_cur && |(pend_w & hw_mask_w);

endmodule

module exc_state_regs_chk
    import exc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                exc_valid,
    input logic [CODE_W-1:0]   exc_code,
    input logic [DATA_W-1:0]   exc_pc,
    input logic                rfe,
    input logic [N_HW_IRQ-1:0] hw_irq,
    input logic [STK_W-1:0]    stk,
    input logic [N_HW_IRQ-1:0] pend,
    input logic [DATA_W-1:0]   epc,
    input logic                ie_cur,
    input logic                user_mode,
    input logic                irq_take
);

    a_r3_push_stack: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> stk == {$past(stk[3:0]), 2'b00});

    a_r3_kernel_off: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (!ie_cur && !user_mode));

    a_r4_pop_stack: assert property (@(posedge clk) disable iff (rst)
        (rfe && !exc_valid) |=> stk == {$past(stk[5:4]), $past(stk[5:2])});

    a_r5_epc_capture: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> epc == $past(exc_pc));

    a_r7_request_seen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend & $past(hw_irq)) == $past(hw_irq));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !(exc_valid && exc_code == EXC_INT) |=> (pend & $past(pend)) == $past(pend));

    a_r9_no_take_disabled: assert property (@(posedge clk) disable iff (rst)
        !ie_cur |-> !irq_take);

endmodule

bind exc_state_regs exc_state_regs_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .exc_pc    (exc_pc),
    .rfe       (rfe),
    .hw_irq    (hw_irq),
    .stk       (stk_w),
    .pend      (pend_w),
    .epc       (epc_q),
    .ie_cur    (ie_cur),
    .user_mode (user_mode),
    .irq_take  (irq_take)
);

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [4:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_fault_valid = 1'b0;
    logic [31:0] exc_fault_addr = '0;
    logic [4:0]  hw_irq = '0;
    logic        rfe = 1'b0;
    logic        ie_cur, user_mode, irq_take;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [31:0] m_status = 0, m_cause = 0, m_epc = 0, m_fault = 0;

    always #5 clk = ~clk;

    exc_state_regs dut_i (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_fault_valid(exc_fault_valid), .exc_fault_addr(exc_fault_addr),
        .hw_irq(hw_irq), .rfe(rfe), .ie_cur(ie_cur), .user_mode(user_mode), .irq_take(irq_take)
    );

    // Reference model: whole-word bit operations per the requirements.
    always @(posedge clk) begin
        logic [31:0] pnd;
        if (rst) begin
            m_status = 0; m_cause = 0; m_epc = 0; m_fault = 0;
        end else begin
            pnd = m_cause & 32'h0000_F800;
            if (exc_valid && exc_code == 4'd0) pnd = 0;
            pnd = pnd | ({27'd0, hw_irq} << 11);
            if (exc_valid) begin
                m_status = (m_status & 32'h0000_FF00) | ((m_status << 2) & 32'h3C);
                m_cause  = {28'd0, exc_code} << 2;
                m_epc    = exc_pc;
                if (exc_fault_valid) m_fault = exc_fault_addr;
            end else begin
                if (rfe)
                    m_status = (m_status & 32'h0000_FF30) | ((m_status >> 2) & 32'hF);
                else if (sw_we && sw_addr == 12)
                    m_status = sw_wdata & 32'h0000_FF3F;
                if (sw_we && sw_addr == 13) m_cause = sw_wdata & 32'h3C;
                if (sw_we && sw_addr == 14) m_epc = sw_wdata;
                if (sw_we && sw_addr == 8)  m_fault = sw_wdata;
            end
            m_cause = (m_cause & 32'h3C) | pnd;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'd8:  return m_fault;
            5'd12: return m_status;
            5'd13: return m_cause;
            5'd14: return m_epc;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge once reset has been applied.
    always @(negedge clk) begin
        if (checks >= 0 && $time > 12) begin
            chk("rd_data (R2)", rd_data, exp_rd(rd_addr));
            chk("ie_cur (R10)", {31'd0, ie_cur}, m_status & 1);
            chk("user_mode (R10)", {31'd0, user_mode}, (m_status >> 1) & 1);
            chk("irq_take (R9)", {31'd0, irq_take},
                {31'd0, m_status[0] & |(m_status[15:11] & m_cause[15:11])});
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        sw_we = 0; exc_valid = 0; rfe = 0; exc_fault_valid = 0;
    endtask

    task automatic read_all();
        foreach (rd_addr_list[k]) begin
            rd_addr = rd_addr_list[k];
            cyc();
        end
    endtask

    logic [4:0] rd_addr_list [6] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3, 5'd31};

    task automatic sw_write(input logic [4:0] a, input logic [31:0] d);
        sw_we = 1; sw_addr = a; sw_wdata = d; cyc(); idle();
    endtask

    task automatic take_exc(input logic [3:0] c, input logic [31:0] pc,
                            input logic fv, input logic [31:0] fa);
        exc_valid = 1; exc_code = c; exc_pc = pc; exc_fault_valid = fv; exc_fault_addr = fa;
        cyc(); idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        cur_req = "R1"; read_all();               // reset state, all zero
        cur_req = "R2"; read_all();

        // R8: software writes, masked fields, ignored pending and unknown numbers
        cur_req = "R8";
        sw_write(5'd12, 32'hFFFF_FFFF); rd_addr = 12; cyc();
        sw_write(5'd12, 32'h0000_A50D); cyc();
        sw_write(5'd13, 32'hFFFF_FFFF); rd_addr = 13; cyc();
        sw_write(5'd14, 32'h1234_5678); rd_addr = 14; cyc();
        sw_write(5'd8,  32'hDEAD_BEEF); rd_addr = 8;  cyc();
        sw_write(5'd9,  32'hFFFF_FFFF); read_all();

        // R3 and R5: exception pushes the stack, records code and PC
        cur_req = "R3"; rd_addr = 12;
        sw_write(5'd12, 32'h0000_FF07); cyc();
        take_exc(4'd12, 32'h0040_0010, 0, 32'h0); cyc();
        cur_req = "R5"; rd_addr = 13; cyc(); rd_addr = 14; cyc();
        cur_req = "R6"; rd_addr = 8; cyc();       // unchanged without fault_valid
        take_exc(4'd5, 32'h0040_0020, 1, 32'h1000_0003); cyc();
        cur_req = "R3"; rd_addr = 12; cyc();

        // R4: return pops; return together with exception gives only the exception
        cur_req = "R4";
        rfe = 1; cyc(); idle(); cyc();
        rfe = 1; cyc(); idle(); cyc();
        sw_write(5'd12, 32'h0000_0017); cyc();
        rfe = 1; exc_valid = 1; exc_code = 4'd9; exc_pc = 32'h44; cyc(); idle();
        rd_addr = 13; cyc(); rd_addr = 12; cyc();
        rfe = 1; sw_we = 1; sw_addr = 12; sw_wdata = 32'h0000_FF3F; cyc(); idle(); cyc();

        // R8: exception blocks software writes in the same cycle
        cur_req = "R8";
        exc_valid = 1; exc_code = 4'd8; exc_pc = 32'h80; sw_we = 1; sw_addr = 14;
        sw_wdata = 32'hCAFE_0000; cyc(); idle(); rd_addr = 14; cyc();

        // R7: pending capture while disabled, sticky, reload on code 0
        cur_req = "R7"; rd_addr = 13;
        sw_write(5'd12, 32'h0000_0000);
        hw_irq = 5'b00101; cyc(); hw_irq = 0; cyc(); cyc();
        take_exc(4'd10, 32'h90, 0, 0); cyc();     // non-interrupt code keeps pending
        hw_irq = 5'b10000;
        take_exc(4'd0, 32'hA0, 0, 0); hw_irq = 0; cyc();
        take_exc(4'd0, 32'hB0, 0, 0); cyc();

        // R9: take only with enable and matching hardware mask; software levels ignored
        cur_req = "R9";
        hw_irq = 5'b00010; cyc(); hw_irq = 0;
        sw_write(5'd12, 32'h0000_0701); cyc();    // software mask only
        sw_write(5'd12, 32'h0000_E801); cyc();    // wrong hardware level
        sw_write(5'd12, 32'h0000_1001); cyc();    // matching level
        sw_write(5'd12, 32'h0000_1000); cyc();    // enable off
        sw_write(5'd12, 32'h0000_1003); cyc();
        cur_req = "R10";
        take_exc(4'd0, 32'hC0, 0, 0); cyc(); cyc();
        rfe = 1; cyc(); idle(); cyc();
        cur_req = "R2"; read_all();

        // R1: reset mid-run returns everything to zero
        cur_req = "R1";
        rst = 1; cyc(); cyc(); rst = 0; read_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule